// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block looks up a 32-bit virtual address in a small set-associative table of page translations built for 4 KiB pages. Each entry holds two 32-bit words. The tag word identifies the page and its owner. The data word gives the physical frame and the access rights. The low bits of the page number select a set, and every way of that set is compared in parallel. On a hit, the block returns the physical address with the page offset carried through unchanged, together with the read, write and execute rights of the matching entry.

The table is filled by a separate maintenance agent through a write port that addresses one way and one set at a time. The lookup side never changes the table. With the default build, a lookup presented in one cycle yields its registered result in the next cycle. A parameter can select a purely combinational result path instead.

Top module: `tlbl_lookup`

## Requirements
- R1: With the default registered output, `rs_valid` is high exactly one cycle after a cycle in which `lk_valid` was high. Reset clears `rs_valid` and marks every stored entry as not valid.
- R2: The set that is searched is `lk_vaddr[12 +: SET_W]`, where SET_W = log2(NUM_ENTRIES/NUM_WAYS). The write port stores `wr_tag` and `wr_data` into the entry selected by `wr_way` and `wr_set`.
- R3: An entry can hit only when its tag valid flag (tag bit 10) is set and its tag page number (tag bits 31:12) equals `lk_vaddr[31:12]`.
- R4: An entry whose global flag (tag bit 11) is set matches any `lk_pid`. Otherwise its stored identifier (tag bits PID_W-1:0) must equal `lk_pid`.
- R5: On a hit, `rs_paddr` equals the frame number (data bits 19:0) shifted left by 12, with `lk_vaddr[11:0]` in the low 12 bits.
- R6: On a hit, `rs_r`, `rs_w` and `rs_x` equal data bits 20, 21 and 22 of the selected entry.
- R7: When the lookup misses, or when no result is valid, `rs_hit`, `rs_paddr`, `rs_r`, `rs_w` and `rs_x` are all zero.
- R8: When several ways of the set hit, the entry in the lowest-numbered way supplies the result.
- R9: A lookup presented in the same cycle as a write to the entry it reads sees the contents from before that write. The next lookup sees the new contents.
- R10: A write replaces only the addressed way and set. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| wr_en | input | 1 | Maintenance write strobe |
| wr_way | input | WAY_W | Way that the write targets |
| wr_set | input | SET_W | Set that the write targets |
| wr_tag | input | 32 | Tag word to store |
| wr_data | input | 32 | Data word to store |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation found |
| rs_paddr | output | 32 | Physical address |
| rs_r | output | 1 | Read permitted |
| rs_w | output | 1 | Write permitted |
| rs_x | output | 1 | Execute permitted |

## Verification
On every cycle, the assertions check that the result strobe follows the request strobe with one cycle of latency. They also check that a miss or an idle slot drives every result field to zero, that a hit only appears alongside a valid result, and that a hit passes the request's page offset through unchanged. Whether the right entry was chosen depends on what is stored in the table. That can only be shown by the bench's scenarios, which cover:
- identifier and global matching;
- cleared valid flags;
- page-number mismatches inside one set;
- several ways hitting at once;
- a write and a lookup to the same entry in the same cycle;
- isolation of entries from writes to their neighbours.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

   localparam int PAGE_SHIFT   = 12;
   localparam int ADDR_W       = 32;
   localparam int VPN_W        = ADDR_W - PAGE_SHIFT;
   localparam int TAG_GLB_BIT  = 11;
   localparam int TAG_VLD_BIT  = 10;
   localparam int PID_MAX_W    = 10;
   localparam int PFN_W        = 20;
   localparam int DAT_R_BIT    = 20;
   localparam int DAT_W_BIT    = 21;
   localparam int DAT_X_BIT    = 22;

   typedef struct packed {
      logic              hit;
      logic [ADDR_W-1:0] paddr;
      logic              r;
      logic              w;
      logic              x;
   } xlat_res_t;

   function automatic logic [VPN_W-1:0] tag_vpn(input logic [31:0] tag);
      return tag[31:PAGE_SHIFT];
   endfunction

endpackage

// File: rtl/tlbl_way_bank.sv
module tlbl_way_bank #(
   parameter int SETS  = 16,
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SET_W-1:0] wset,
   input  logic [31:0]      wtag,
   input  logic [31:0]      wdata,
   input  logic [SET_W-1:0] rset,
   output logic [31:0]      rtag,
   output logic [31:0]      rdata
);

   logic [31:0] tag_q  [SETS];
   logic [31:0] data_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else if (we) begin
         tag_q[wset]  <= wtag;
         data_q[wset] <= wdata;
      end
   end

   assign rtag  = tag_q[rset];
   assign rdata = data_q[rset];

endmodule

// File: rtl/tlbl_tag_cmp.sv
module tlbl_tag_cmp
   import tlbl_pkg::*;
#(
   parameter int PID_W = 8
) (
   input  logic [31:0]      tag,
   input  logic [VPN_W-1:0] vpn,
   input  logic [PID_W-1:0] pid,
   output logic             match
);

   logic vpn_eq;
   logic owner_ok;

   assign vpn_eq   = (tag_vpn(tag) == vpn);
   assign owner_ok = tag[TAG_GLB_BIT] || (tag[PID_W-1:0] == pid);
   assign match    = tag[TAG_VLD_BIT] && vpn_eq && owner_ok;

   generate
      if (PID_W < PID_MAX_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^tag[PID_MAX_W-1:PID_W];
      end
   endgenerate

endmodule

// File: rtl/tlbl_way_pick.sv
module tlbl_way_pick #(
   parameter int WAYS = 4
) (
   input  logic [WAYS-1:0]       match,
   input  logic [WAYS-1:0][31:0] data,
   output logic                  any_hit,
   output logic [31:0]           sel_data
);

   always_comb begin
      any_hit  = |match;
      sel_data = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) sel_data = data[w];
      end
   end

endmodule

// File: rtl/tlbl_lookup.sv
module tlbl_lookup
   import tlbl_pkg::*;
#(
   parameter int NUM_WAYS    = 4,
   parameter int NUM_ENTRIES = 64,
   parameter int PID_W       = 8,
   parameter bit REG_OUT     = 1'b1,
   parameter int SETS        = NUM_ENTRIES / NUM_WAYS,
   parameter int SET_W       = $clog2(SETS),
   parameter int WAY_W       = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [31:0]      lk_vaddr,
   input  logic [PID_W-1:0] lk_pid,
   input  logic             wr_en,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [SET_W-1:0] wr_set,
   input  logic [31:0]      wr_tag,
   input  logic [31:0]      wr_data,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic [31:0]      rs_paddr,
   output logic             rs_r,
   output logic             rs_w,
   output logic             rs_x
);

   generate
      if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
         $error("NUM_WAYS must be a power of two, at least 2");
      end
      if (NUM_ENTRIES % NUM_WAYS != 0) begin : g_bad_entries
         $error("NUM_ENTRIES must be a multiple of NUM_WAYS");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("set count must be a power of two, at least 2");
      end
      if (SET_W > VPN_W) begin : g_bad_setw
         $error("set index wider than the page number");
      end
      if (PID_W < 1 || PID_W > PID_MAX_W) begin : g_bad_pid
         $error("PID_W must lie in 1..10");
      end
   endgenerate

   logic [SET_W-1:0]            rd_set;
   logic [VPN_W-1:0]            rd_vpn;
   logic [NUM_WAYS-1:0]         way_match;
   logic [NUM_WAYS-1:0][31:0]   way_data;
   logic                        any_hit;
   logic [31:0]                 sel_data;
   xlat_res_t                   res_d;

   assign rd_vpn = lk_vaddr[31:PAGE_SHIFT];
   assign rd_set = lk_vaddr[PAGE_SHIFT +: SET_W];

   generate
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         logic        bank_we;
         logic [31:0] bank_tag;

         assign bank_we = wr_en && (wr_way == WAY_W'(w));

         tlbl_way_bank #(
            .SETS  (SETS),
            .SET_W (SET_W)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .wset  (wr_set),
            .wtag  (wr_tag),
            .wdata (wr_data),
            .rset  (rd_set),
            .rtag  (bank_tag),
            .rdata (way_data[w])
         );

         tlbl_tag_cmp #(
            .PID_W (PID_W)
         ) u_cmp (
            .tag   (bank_tag),
            .vpn   (rd_vpn),
            .pid   (lk_pid),
            .match (way_match[w])
         );
      end
   endgenerate

   tlbl_way_pick #(
      .WAYS (NUM_WAYS)
   ) u_pick (
      .match    (way_match),
      .data     (way_data),
      .any_hit  (any_hit),
      .sel_data (sel_data)
   );

   logic unused_data;
   assign unused_data = ^sel_data[31:DAT_X_BIT+1];

   always_comb begin
      res_d = '0;
      if (lk_valid && any_hit) begin
         res_d.hit   = 1'b1;
         res_d.paddr = {sel_data[PFN_W-1:0], lk_vaddr[PAGE_SHIFT-1:0]};
         res_d.r     = sel_data[DAT_R_BIT];
         res_d.w     = sel_data[DAT_W_BIT];
         res_d.x     = sel_data[DAT_X_BIT];
      end
   end

   xlat_res_t res_o;
   logic      vld_o;

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_o <= '0;
               vld_o <= 1'b0;
            end else begin
               res_o <= res_d;
               vld_o <= lk_valid;
            end
         end
      end else begin : g_comb_out
         assign res_o = res_d;
         assign vld_o = lk_valid;
      end
   endgenerate

   assign rs_valid = vld_o;
   assign rs_hit   = res_o.hit;
   assign rs_paddr = res_o.paddr;
   assign rs_r     = res_o.r;
   assign rs_w     = res_o.w;
   assign rs_x     = res_o.x;

endmodule

// File: rtl/tlbl_lookup_chk.sv
module tlbl_lookup_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        lk_valid,
   input logic [31:0] lk_vaddr,
   input logic        rs_valid,
   input logic        rs_hit,
   input logic [31:0] rs_paddr,
   input logic        rs_r,
   input logic        rs_w,
   input logic        rs_x
);

   // R7: a miss or an idle slot leaves every result field at zero
   a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> (rs_paddr == 32'h0 && !rs_r && !rs_w && !rs_x));

   // R7: a hit never appears without a valid result
   a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> rs_valid);

   generate
      if (REG_OUT) begin : g_reg
         // R1: a request yields a result one cycle later
         a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            lk_valid |=> rs_valid);
         // R1: no request means no result one cycle later
         a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !lk_valid |=> !rs_valid);
         // R5: the page offset passes through on a hit
         a_r5_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
            lk_valid |=> (!rs_hit || rs_paddr[11:0] == $past(lk_vaddr[11:0])));
      end else begin : g_comb
         // R1: a result is valid in the request cycle
         a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            rs_valid == lk_valid);
         // R5: the page offset passes through on a hit
         a_r5_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
            rs_hit |-> rs_paddr[11:0] == lk_vaddr[11:0]);
      end
   endgenerate

endmodule

bind tlbl_lookup tlbl_lookup_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_tlbl_lookup.sv
module sim_tlbl_lookup;

   localparam int CLK_PERIOD = 10;
   localparam int WAYS  = 4;
   localparam int ENTR  = 64;
   localparam int PIDW  = 8;
   localparam int SETS  = ENTR / WAYS;
   localparam int SETW  = $clog2(SETS);
   localparam int WAYW  = $clog2(WAYS);

   typedef struct packed {
      logic        hit;
      logic [31:0] paddr;
      logic        r;
      logic        w;
      logic        x;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lk_valid = 1'b0;
   logic [31:0]     lk_vaddr = '0;
   logic [PIDW-1:0] lk_pid = '0;
   logic            wr_en = 1'b0;
   logic [WAYW-1:0] wr_way = '0;
   logic [SETW-1:0] wr_set = '0;
   logic [31:0]     wr_tag = '0;
   logic [31:0]     wr_data = '0;
   logic            rs_valid, rs_hit, rs_r, rs_w, rs_x;
   logic [31:0]     rs_paddr;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_tag  [WAYS][SETS];
   logic [31:0] m_data [WAYS][SETS];
   exp_t  expq[$];
   string nameq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tlbl_lookup #(
      .NUM_WAYS    (WAYS),
      .NUM_ENTRIES (ENTR),
      .PID_W       (PIDW)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_valid (lk_valid),
      .lk_vaddr (lk_vaddr),
      .lk_pid   (lk_pid),
      .wr_en    (wr_en),
      .wr_way   (wr_way),
      .wr_set   (wr_set),
      .wr_tag   (wr_tag),
      .wr_data  (wr_data),
      .rs_valid (rs_valid),
      .rs_hit   (rs_hit),
      .rs_paddr (rs_paddr),
      .rs_r     (rs_r),
      .rs_w     (rs_w),
      .rs_x     (rs_x)
   );

   // Tag: page number 31:12, global 11, valid 10, identifier PIDW-1:0
   function automatic logic [31:0] mk_tag(input logic [19:0] vpn, input logic g,
                                          input logic v, input logic [PIDW-1:0] pid);
      logic [31:0] t;
      t = '0;
      t[31:12] = vpn;
      t[11] = g;
      t[10] = v;
      t[PIDW-1:0] = pid;
      return t;
   endfunction

   // Data: frame 19:0, read 20, write 21, execute 22
   function automatic logic [31:0] mk_data(input logic [19:0] pfn, input logic r,
                                           input logic w, input logic x);
      return {9'h0, x, w, r, pfn};
   endfunction

   function automatic exp_t model(input logic [31:0] va, input logic [PIDW-1:0] pid);
      exp_t e;
      int   s;
      e = '0;
      s = int'(va[12 +: SETW]);
      for (int w = 0; w < WAYS; w++) begin
         logic [31:0] t;
         t = m_tag[w][s];
         if (!e.hit && t[10] && t[31:12] == va[31:12] &&
             (t[11] || t[PIDW-1:0] == pid)) begin
            e.hit   = 1'b1;
            e.paddr = {m_data[w][s][19:0], va[11:0]};
            e.r     = m_data[w][s][20];
            e.w     = m_data[w][s][21];
            e.x     = m_data[w][s][22];
         end
      end
      return e;
   endfunction

   // Driver: one cycle, optional write and optional lookup
   task automatic step(input logic we, input int way, input int set,
                       input logic [31:0] tag, input logic [31:0] data,
                       input logic lv, input logic [31:0] va,
                       input logic [PIDW-1:0] pid, input string rq);
      if (lv) begin
         expq.push_back(model(va, pid));
         nameq.push_back(rq);
      end
      if (we) begin
         m_tag[way][set]  = tag;
         m_data[way][set] = data;
      end
      wr_en    = we;
      wr_way   = WAYW'(way);
      wr_set   = SETW'(set);
      wr_tag   = tag;
      wr_data  = data;
      lk_valid = lv;
      lk_vaddr = va;
      lk_pid   = pid;
      @(negedge clk);
   endtask

   task automatic wr(input int way, input int set, input logic [31:0] tag,
                     input logic [31:0] data);
      step(1'b1, way, set, tag, data, 1'b0, '0, '0, "");
   endtask

   task automatic lk(input logic [31:0] va, input logic [PIDW-1:0] pid,
                     input string rq);
      step(1'b0, 0, 0, '0, '0, 1'b1, va, pid, rq);
   endtask

   task automatic idle();
      step(1'b0, 0, 0, '0, '0, 1'b0, '0, '0, "");
   endtask

   // Monitor: compares each result with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && rs_valid) begin
         n_chk++;
         if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R1 result without request: got valid=1 expected valid=0");
         end else begin
            exp_t  e;
            exp_t  g;
            string nm;
            e  = expq.pop_front();
            nm = nameq.pop_front();
            g  = {rs_hit, rs_paddr, rs_r, rs_w, rs_x};
            if (g != e) begin
               n_fail++;
               $display("FAIL %s: got hit=%0d pa=%h rwx=%b%b%b expected hit=%0d pa=%h rwx=%b%b%b",
                        nm, g.hit, g.paddr, g.r, g.w, g.x, e.hit, e.paddr, e.r, e.w, e.x);
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      summary();
   end

   initial begin
      for (int w = 0; w < WAYS; w++)
         for (int s = 0; s < SETS; s++) begin
            m_tag[w][s]  = '0;
            m_data[w][s] = '0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (rs_valid !== 1'b0 || rs_hit !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset state: got valid=%b hit=%b expected 0 0", rs_valid, rs_hit);
      end

      lk(32'h1234_3ABC, 8'd5, "R1 empty table misses");
      lk(32'h0000_0000, 8'd0, "R7 zero address misses after reset");

      // set 3, way 0: private page for identifier 5, read only
      wr(0, 3, mk_tag(20'h12343, 1'b0, 1'b1, 8'd5), mk_data(20'h12345, 1'b1, 1'b0, 1'b0));
      lk(32'h1234_3ABC, 8'd5, "R3 R5 R6 private hit");
      lk(32'h1234_3ABC, 8'd6, "R4 identifier mismatch misses");
      lk(32'h5678_3ABC, 8'd5, "R3 page mismatch in same set");
      lk(32'h1234_3001, 8'd5, "R5 other offset");

      // set 9, way 1: global page, write+execute
      wr(1, 9, mk_tag(20'hCAFE9, 1'b1, 1'b1, 8'd77), mk_data(20'h0BEEF, 1'b0, 1'b1, 1'b1));
      lk(32'hCAFE_9FFF, 8'd3, "R4 global ignores identifier");
      lk(32'hCAFE_9000, 8'd77, "R6 write execute flags");

      // invalid entry with matching page
      wr(2, 5, mk_tag(20'hABCD5, 1'b1, 1'b0, 8'd1), mk_data(20'h11111, 1'b1, 1'b1, 1'b1));
      lk(32'hABCD_5010, 8'd1, "R3 cleared valid flag misses");

      // set index: same way, two sets
      wr(0, 6, mk_tag(20'h00016, 1'b0, 1'b1, 8'd2), mk_data(20'h00AAA, 1'b1, 1'b1, 1'b0));
      lk(32'h0001_6123, 8'd2, "R2 set from address bits");
      lk(32'h0001_7123, 8'd2, "R2 neighbouring set misses");

      // several ways hit in set 7
      wr(3, 7, mk_tag(20'h00077, 1'b1, 1'b1, 8'd0), mk_data(20'h33333, 1'b0, 1'b0, 1'b1));
      wr(2, 7, mk_tag(20'h00077, 1'b0, 1'b1, 8'd9), mk_data(20'h22222, 1'b1, 1'b0, 1'b0));
      lk(32'h0007_7444, 8'd9, "R8 lowest way wins");
      lk(32'h0007_7444, 8'd8, "R8 only higher way matches");
      wr(2, 7, mk_tag(20'h00077, 1'b0, 1'b0, 8'd9), mk_data(20'h22222, 1'b1, 1'b0, 1'b0));
      lk(32'h0007_7444, 8'd9, "R10 rewrite lets next way win");

      // write and lookup in the same cycle
      step(1'b1, 0, 3, mk_tag(20'h12343, 1'b0, 1'b1, 8'd5), mk_data(20'hFEDCB, 1'b1, 1'b1, 1'b1),
           1'b1, 32'h1234_3ABC, 8'd5, "R9 same cycle sees old entry");
      lk(32'h1234_3ABC, 8'd5, "R9 next lookup sees new entry");

      // writes elsewhere leave existing entries alone
      wr(1, 3, mk_tag(20'h99993, 1'b0, 1'b1, 8'd5), mk_data(20'h44444, 1'b1, 1'b0, 1'b0));
      lk(32'hCAFE_9800, 8'd1, "R10 untouched global entry");
      lk(32'h1234_3ABC, 8'd5, "R10 way 0 kept after way 1 write");
      lk(32'h9999_3ABC, 8'd5, "R10 way 1 new entry");
      idle();
      lk(32'h0001_6FFF, 8'd2, "R1 result after idle slot");
      idle();
      idle();

      n_chk++;
      if (expq.size() != 0) begin
         n_fail++;
         $display("FAIL R1 results outstanding: got %0d expected 0", expq.size());
      end
      summary();
   end

endmodule